// File: doc/BRIEF.md
# Command-Driven Two-Wire Thermometer Target

This block is a synthesizable target device for a two-wire I2C bus that behaves like a simple digital thermometer. The master addresses it and writes a one-byte command. That command either fills an 8-bit configuration register, latches a new temperature sample, or selects the temperature for reading. The temperature itself arrives on a 16-bit parallel input. It is captured into an internal readout register only when the conversion command arrives, so the value the master reads stays constant between conversions.

The bus lines are open-drain. The block samples SCL and SDA as plain inputs and pulls SDA low through a separate drive enable. SCL is never driven, because the block does not stretch the clock. Both lines pass through a two-flop synchronizer. Start and stop conditions and SCL edges are then found from the synchronized values. To read, the master writes the temperature-select command, issues a repeated start with the read address, and clocks out two bytes.

Top module: `i2c_thermo_slave`

## Requirements
- R1: After reset the configuration output is 0x00, SDA is released, and a temperature read before any conversion returns 0x0000.
- R2: The target acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits are 1001000. Bit 0 of the address byte selects the direction: 0 for write, 1 for read.
- R3: An address that does not match is not acknowledged, and every later byte of that transaction is ignored (not acknowledged, no register change).
- R4: Command 0xAC is acknowledged. The next byte written in the same transaction is acknowledged and stored in the configuration register, which drives `cfg_o`.
- R5: Command 0xEE is acknowledged, and the value on `temp_in` is copied into the readout register at the end of that command byte.
- R6: After command 0xAA and a repeated start with the read address, the target sends the readout register most significant byte first, then the least significant byte, each byte MSB first.
- R7: The readout register changes only on a conversion command. Changes on `temp_in` at other times are not visible to reads.
- R8: A command byte other than 0xAC, 0xEE or 0xAA is not acknowledged, and the rest of the transaction is ignored.
- R9: When the master answers a read byte with NACK, the target releases SDA and stays off the bus until the next start or stop.
- R10: A start condition (SDA falls while SCL is high) or a stop condition (SDA rises while SCL is high) clears the bit counter and abandons any partial byte, and a new transaction then works normally.
- R11: Once the configuration data byte has been stored, further bytes in that transaction are not acknowledged and do not change the configuration.
- R12: If the master acknowledges the second read byte, the target continues with the most significant byte again, alternating between the two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_drive_low | output | 1 | When high, SDA is pulled low |
| temp_in | input | 16 | Parallel temperature sample captured on conversion |
| cfg_o | output | 8 | Current configuration register value |

## Verification
The assertions check, on every cycle, the invariants that tie internal strobes to visible state. The configuration and readout registers move only on their write strobes, and a conversion loads exactly the sampled input. A start always clears the bit counter, a stop always releases SDA, and the bit counter never passes eight. Only the bench's bus scenarios can show the protocol itself. Those cover acknowledge timing, address and command rejection, the byte order of reads, the alternation on continued reads, the release after a NACK, and recovery after a byte cut short by a new start.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  localparam logic [7:0] OP_SET_CFG   = 8'hAC;
  localparam logic [7:0] OP_CONVERT   = 8'hEE;
  localparam logic [7:0] OP_SEL_TEMP  = 8'hAA;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_CMD,
    XS_DATA,
    XS_ACK,
    XS_TX,
    XS_TX_ACK,
    XS_IGNORE
  } xfer_st_t;

  typedef enum logic [1:0] {
    AFT_CMD,
    AFT_DATA,
    AFT_TX,
    AFT_IGNORE
  } after_ack_t;

endpackage

// File: rtl/thermo_sync.sv
module thermo_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= {STAGES{RST_VAL[g]}};
        end else begin
          pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
        end
      end
      assign q_o[g] = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/thermo_bus_events.sv
module thermo_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;

endmodule

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
  import thermo_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter int         DW       = 8,
  localparam int        CW       = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic [2*DW-1:0] rd_word,
  output logic          cfg_we,
  output logic [DW-1:0] cfg_wdata,
  output logic          conv_go,
  output logic          sda_drive_low,
  output logic [CW-1:0] bit_cnt
);

  localparam logic [CW-1:0] CNT_FULL = CW'(DW);

  xfer_st_t   st_q, st_n;
  after_ack_t aft_q, aft_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] tx_q, tx_n;
  logic          lsb_next_q, lsb_next_n;
  logic          mnack_q, mnack_n;

  logic byte_in_done;
  assign byte_in_done = scl_fall && (cnt_q == CNT_FULL);

  // next-state logic
  always_comb begin
    st_n       = st_q;
    aft_n      = aft_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    tx_n       = tx_q;
    lsb_next_n = lsb_next_q;
    mnack_n    = mnack_q;
    cfg_we     = 1'b0;
    conv_go    = 1'b0;

    if (bus_start) begin
      st_n  = XS_ADDR;
      cnt_n = '0;
    end else if (bus_stop) begin
      st_n  = XS_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        XS_ADDR, XS_CMD, XS_DATA: begin
          if (scl_rise && (cnt_q != CNT_FULL)) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (byte_in_done) begin
            cnt_n = '0;
            if (st_q == XS_ADDR) begin
              if (sh_q[DW-1:1] == DEV_ADDR) begin
                st_n  = XS_ACK;
                aft_n = sh_q[0] ? AFT_TX : AFT_CMD;
              end else begin
                st_n = XS_IGNORE;
              end
            end else if (st_q == XS_CMD) begin
              if (sh_q == OP_SET_CFG) begin
                st_n  = XS_ACK;
                aft_n = AFT_DATA;
              end else if (sh_q == OP_CONVERT) begin
                st_n    = XS_ACK;
                aft_n   = AFT_IGNORE;
                conv_go = 1'b1;
              end else if (sh_q == OP_SEL_TEMP) begin
                st_n  = XS_ACK;
                aft_n = AFT_IGNORE;
              end else begin
                st_n = XS_IGNORE;
              end
            end else begin
              cfg_we = 1'b1;
              st_n   = XS_ACK;
              aft_n  = AFT_IGNORE;
            end
          end
        end
        XS_ACK: begin
          if (scl_fall) begin
            unique case (aft_q)
              AFT_CMD:  st_n = XS_CMD;
              AFT_DATA: st_n = XS_DATA;
              AFT_TX: begin
                st_n       = XS_TX;
                tx_n       = rd_word[2*DW-1:DW];
                lsb_next_n = 1'b1;
              end
              default:  st_n = XS_IGNORE;
            endcase
          end
        end
        XS_TX: begin
          if (scl_rise && (cnt_q != CNT_FULL)) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              st_n  = XS_TX_ACK;
              cnt_n = '0;
            end else begin
              tx_n = {tx_q[DW-2:0], 1'b0};
            end
          end
        end
        XS_TX_ACK: begin
          if (scl_rise) begin
            mnack_n = sda_s;
          end else if (scl_fall) begin
            if (!mnack_q) begin
              st_n       = XS_TX;
              tx_n       = lsb_next_q ? rd_word[DW-1:0] : rd_word[2*DW-1:DW];
              lsb_next_n = ~lsb_next_q;
            end else begin
              st_n = XS_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= XS_IDLE;
      aft_q      <= AFT_IGNORE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      lsb_next_q <= 1'b0;
      mnack_q    <= 1'b1;
    end else begin
      st_q       <= st_n;
      aft_q      <= aft_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      tx_q       <= tx_n;
      lsb_next_q <= lsb_next_n;
      mnack_q    <= mnack_n;
    end
  end

  assign sda_drive_low = (st_q == XS_ACK) || ((st_q == XS_TX) && !tx_q[DW-1]);
  assign cfg_wdata     = sh_q;
  assign bit_cnt       = cnt_q;

endmodule

// File: rtl/i2c_thermo_slave.sv
module i2c_thermo_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001000,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_drive_low,
  input  logic [15:0]   temp_in,
  output logic [7:0]    cfg_o
);

  localparam int CNT_W  = $clog2(DW + 1);
  localparam int WORD_W = 2 * DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  logic [1:0] line_s;
  logic       bus_start, bus_stop, scl_rise, scl_fall;
  logic       cfg_we, conv_go;
  logic [DW-1:0]     cfg_wdata;
  logic [DW-1:0]     cfg_q;
  logic [WORD_W-1:0] temp_q;
  logic [CNT_W-1:0]  bit_cnt;

  thermo_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(core_rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  (line_s)
  );

  thermo_bus_events u_events (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .start_o   (bus_start),
    .stop_o    (bus_stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  thermo_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .DW      (DW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (line_s[0]),
    .rd_word      (temp_q),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .conv_go      (conv_go),
    .sda_drive_low(sda_drive_low),
    .bit_cnt      (bit_cnt)
  );

  // configuration register
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  // readout register, loaded on conversion only
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      temp_q <= '0;
    end else if (conv_go) begin
      temp_q <= temp_in[WORD_W-1:0];
    end
  end

  assign cfg_o = cfg_q[7:0];

endmodule

// File: rtl/thermo_chk.sv
module thermo_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic [CW-1:0] bit_cnt,
  input logic          sda_drive_low,
  input logic          cfg_we,
  input logic [7:0]    cfg_o,
  input logic          conv_go,
  input logic [2*DW-1:0] temp_q,
  input logic [15:0]   temp_in
);

  AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (bit_cnt == '0)); // R10

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_drive_low); // R10

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt <= CW'(DW))); // R10

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_o)); // R4

  AST_READOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_go |=> $stable(temp_q)); // R7

  AST_READOUT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> (temp_q == $past(temp_in[2*DW-1:0]))); // R5

endmodule

bind i2c_thermo_slave thermo_chk #(.DW(DW), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_start    (bus_start),
  .bus_stop     (bus_stop),
  .bit_cnt      (bit_cnt),
  .sda_drive_low(sda_drive_low),
  .cfg_we       (cfg_we),
  .cfg_o        (cfg_o),
  .conv_go      (conv_go),
  .temp_q       (temp_q),
  .temp_in      (temp_in)
);

// File: tb/i2c_thermo_slave_test.sv
module i2c_thermo_slave_test;

  localparam int HALF = 8;
  localparam int NVEC = 6;
  // {configuration byte, temperature word}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h19_1980, 24'h00_FF80, 24'hFF_0000,
    24'hA5_7FFF, 24'h3C_8001, 24'h5A_0A50
  };

  logic clk, rst_n;
  logic scl_m, sda_m;
  logic sda_line;
  logic sda_drive_low;
  logic [15:0] temp_in;
  logic [7:0]  cfg_o;

  int n_run, n_fail;
  bit done;

  assign sda_line = sda_m & ~sda_drive_low;

  i2c_thermo_slave uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_drive_low(sda_drive_low),
    .temp_in      (temp_in),
    .cfg_o        (cfg_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF / 2);
    ack = sda_line;
    tick(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl_m = 1'b1; tick(HALF / 2);
      b[i] = sda_line;
      tick(HALF / 2);
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = nack; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic write_cfg(input logic [6:0] a, input logic [7:0] v, output logic [2:0] acks);
    bus_start();
    wr_byte({a, 1'b0}, acks[2]);
    wr_byte(8'hAC, acks[1]);
    wr_byte(v, acks[0]);
    bus_stop();
  endtask

  task automatic convert(output logic [1:0] acks);
    bus_start();
    wr_byte(8'h90, acks[1]);
    wr_byte(8'hEE, acks[0]);
    bus_stop();
  endtask

  task automatic read_temp(output logic [15:0] w, output logic [2:0] acks, output logic rel);
    bus_start();
    wr_byte(8'h90, acks[2]);
    wr_byte(8'hAA, acks[1]);
    bus_start();
    wr_byte(8'h91, acks[0]);
    rd_byte(1'b0, w[15:8]);
    rd_byte(1'b1, w[7:0]);
    rel = sda_drive_low;
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0]  a3;
    logic [1:0]  a2;
    logic        a1, rel;
    logic [15:0] w;
    logic [7:0]  b;
    n_run = 0; n_fail = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1; temp_in = 16'h0000;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state
    check("R1 cfg after reset", cfg_o, 8'h00);
    check("R1 sda released after reset", sda_drive_low, 1'b0);
    temp_in = 16'h1234;
    read_temp(w, a3, rel);
    check("R1 read before conversion", w, 16'h0000);

    // table of configuration and temperature vectors
    for (int k = 0; k < NVEC; k++) begin
      write_cfg(7'h48, VEC[k][23:16], a3);
      check("R2 R4 cfg write acks", a3, 3'b000);
      check("R4 cfg stored", cfg_o, VEC[k][23:16]);
      temp_in = VEC[k][15:0];
      convert(a2);
      check("R5 convert acks", a2, 2'b00);
      temp_in = ~VEC[k][15:0];
      read_temp(w, a3, rel);
      check("R2 R6 read acks", a3, 3'b000);
      check("R6 R7 read word", w, VEC[k][15:0]);
      check("R9 sda released after nack", rel, 1'b0);
    end

    // R3: wrong address ignored
    write_cfg(7'h49, 8'hC3, a3);
    check("R3 wrong address nacked, bytes ignored", a3, 3'b111);
    check("R3 cfg unchanged", cfg_o, 8'h5A);

    // R8: unknown command
    bus_start();
    wr_byte(8'h90, a1);
    check("R2 address ack", a1, 1'b0);
    wr_byte(8'h33, a1);
    check("R8 unknown command nacked", a1, 1'b1);
    wr_byte(8'h77, a1);
    check("R8 following byte ignored", a1, 1'b1);
    bus_stop();
    check("R8 cfg unchanged", cfg_o, 8'h5A);

    // R11: extra byte after configuration data
    bus_start();
    wr_byte(8'h90, a1);
    wr_byte(8'hAC, a1);
    wr_byte(8'h11, a1);
    check("R11 data byte acked", a1, 1'b0);
    wr_byte(8'h22, a1);
    check("R11 extra byte nacked", a1, 1'b1);
    bus_stop();
    check("R11 cfg holds first data", cfg_o, 8'h11);

    // R10: partial byte abandoned by start, then by stop
    bus_start();
    send_bits(8'hFF, 3);
    bus_start();
    wr_byte(8'h90, a1);
    check("R10 ack after restart", a1, 1'b0);
    wr_byte(8'hAC, a1);
    send_bits(8'h0F, 4);
    bus_stop();
    check("R10 partial data not stored", cfg_o, 8'h11);
    write_cfg(7'h48, 8'h3C, a3);
    check("R10 transaction after stop", {5'b0, a3}, 8'h00);
    check("R10 cfg after recovery", cfg_o, 8'h3C);

    // R7: input change without conversion
    temp_in = 16'hBEEF;
    read_temp(w, a3, rel);
    check("R7 readout unchanged", w, 16'h0A50);

    // R12: master keeps acknowledging
    temp_in = 16'hC381;
    convert(a2);
    bus_start();
    wr_byte(8'h90, a1);
    wr_byte(8'hAA, a1);
    bus_start();
    wr_byte(8'h91, a1);
    rd_byte(1'b0, b);
    check("R6 msb first", b, 8'hC3);
    rd_byte(1'b0, b);
    check("R6 lsb second", b, 8'h81);
    rd_byte(1'b1, b);
    check("R12 wraps to msb", b, 8'hC3);
    check("R9 released after nack", sda_drive_low, 1'b0);
    bus_stop();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule